// File: doc/BRIEF.md
# Dual-Channel Shared Byte FIFO with Threshold Service Requests

This block links an external host and an internal processor through one shared 128-entry RAM. The RAM holds two circular queues. The lower half is the inbound queue, which the host fills and the processor drains. The upper half is the outbound queue, which the processor fills and the host drains. Each outbound entry carries a ninth bit that marks it as an in-band command rather than plain data. The host and the processor each present single-cycle read or write strobes. The RAM gives alternate clocks to the two sides, so neither side ever blocks the other.

Each queue drives a service-request line towards the host. The inbound line reports that enough room is free. The outbound line reports that enough entries are waiting. Both levels come from 7-bit threshold inputs. The processor can also freeze the block. While frozen, host traffic is dropped and the processor may overwrite any of the four queue pointers. Illegal accesses, meaning a write to a full queue or a read from an empty queue, change nothing and latch a sticky error bit.

Top module: `hostlink_fifo`

## Requirements
- R1: Reset (synchronous, active high) clears all pointers and error bits and drops both rvalid outputs. One clock after reset is released, `out_status` reads 0 and `host_in_req` shows an empty inbound queue.
- R2: Bytes written by the host with `host_wr` come out on `cpu_rdata` in write order when the processor strobes `cpu_rd`. The inbound queue holds 64 entries and its pointers wrap at the end of its half of the RAM.
- R3: Bytes and tag bits written by the processor with `cpu_wr`/`cpu_wtag` come out in write order on `host_rdata`/`host_rtag` when the host strobes `host_rd`. The outbound queue holds 64 entries and wraps the same way.
- R4: `host_in_req` is high exactly when the number of free inbound entries is at least the effective inbound threshold. The effective threshold is `in_thresh`, or 1 when `in_thresh` is 0.
- R5: `out_status[6:0]` gives the outbound occupancy. `out_status[7]` and `host_out_req` are high exactly when that occupancy is at least the effective outbound threshold, which is `out_thresh`, or 1 when it is 0.
- R6: RAM slots alternate between the host and the processor on successive clocks, starting with the host after reset. A strobe is served within one extra cycle of being presented. Read data appears with its rvalid one clock after the serving edge, so a side never sees rvalid on two consecutive clocks.
- R7: A write to a full queue or a read from an empty queue is ignored and sets a sticky bit in `err_flags`. The bits are: bit 0 host write to full inbound, bit 1 processor read of empty inbound, bit 2 processor write to full outbound, bit 3 host read of empty outbound. Writing 1 to the matching `err_clr` bit clears it.
- R8: While `freeze` is high, host strobes are dropped and cause no transfer and no error. A `ptr_ld` pulse then loads `ptr_val` into the pointer chosen by `ptr_sel`: 0 inbound read, 1 inbound write, 2 outbound read, 3 outbound write. Occupancy is the write pointer minus the read pointer, modulo 128.
- R9: A `ptr_ld` pulse while `freeze` is low has no effect on any pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe into the inbound queue |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe from the outbound queue |
| host_rdata | output | 8 | Outbound byte read by the host |
| host_rtag | output | 1 | Command tag of the outbound entry read |
| host_rvalid | output | 1 | Host read data valid |
| host_in_req | output | 1 | Inbound service request |
| host_out_req | output | 1 | Outbound service request |
| out_status | output | 8 | Bit 7 outbound request, bits 6:0 outbound occupancy |
| cpu_wr | input | 1 | Processor write strobe into the outbound queue |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_wtag | input | 1 | Marks the written entry as a command |
| cpu_rd | input | 1 | Processor read strobe from the inbound queue |
| cpu_rdata | output | 8 | Inbound byte read by the processor |
| cpu_rvalid | output | 1 | Processor read data valid |
| in_thresh | input | 7 | Inbound free-space threshold |
| out_thresh | input | 7 | Outbound occupancy threshold |
| freeze | input | 1 | Freeze mode: host traffic dropped, pointer loads allowed |
| ptr_ld | input | 1 | Pointer load strobe |
| ptr_sel | input | 2 | Pointer chosen for loading |
| ptr_val | input | 7 | Value loaded into the chosen pointer, wrap bit included |
| err_flags | output | 4 | Sticky access error bits |
| err_clr | input | 4 | Write-1-to-clear for `err_flags` |

## Verification
The assertions assume three things about the inputs. Each side strobes at most once every two clocks and never reads and writes in the same cycle. Pointers are loaded only with values whose difference stays within one queue depth. The occupancy bound is checked only outside freeze. The stimulus spaces every strobe by at least three clocks. It loads only pointer pairs that differ by a few entries, and it issues simultaneous host and processor strobes only as a single pair, so the alternating slot scheme is exercised without breaking the pacing rule.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;
  // Index of each pointer, also the ptr_sel code that loads it
  localparam int P_IN_RD  = 0;
  localparam int P_IN_WR  = 1;
  localparam int P_OUT_RD = 2;
  localparam int P_OUT_WR = 3;
  localparam int N_PTR    = 4;

  // Sticky error bit positions
  localparam int E_IN_FULL   = 0;
  localparam int E_IN_EMPTY  = 1;
  localparam int E_OUT_FULL  = 2;
  localparam int E_OUT_EMPTY = 3;
  localparam int N_ERR       = 4;
endpackage

// File: rtl/hostlink_port.sv
// One requester's strobe holder: serves in its own slot, else holds one cycle.
module hostlink_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         drop,
  input  logic         my_slot,
  input  logic         rd_stb,
  input  logic         wr_stb,
  input  logic [W-1:0] wdata,
  output logic         go,
  output logic         go_wr,
  output logic [W-1:0] go_data
);
  logic         pend, pend_wr;
  logic [W-1:0] pend_data;
  logic         new_v, cur_v;

  always_comb begin
    new_v   = (rd_stb | wr_stb) & ~drop;
    cur_v   = (pend & ~drop) | new_v;
    go_wr   = pend ? pend_wr : wr_stb;
    go_data = pend ? pend_data : wdata;
    go      = cur_v & my_slot;
  end

  always_ff @(posedge clk) begin
    if (rst || drop) begin
      pend      <= 1'b0;
      pend_wr   <= 1'b0;
      pend_data <= '0;
    end else if (cur_v && !my_slot) begin
      pend      <= 1'b1;
      pend_wr   <= go_wr;
      pend_data <= go_data;
    end else if (go) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/hostlink_ptr.sv
module hostlink_ptr #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (ld)  ptr <= ld_val;
    else if (inc) ptr <= ptr + W'(1);
  end
endmodule

// File: rtl/hostlink_ram.sv
// Single-port RAM with registered read, no reset on the array.
module hostlink_ram #(
  parameter int AW = 7,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int NWORDS = 2 ** AW;
  logic [DW-1:0] mem [NWORDS];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/hostlink_status.sv
module hostlink_status #(
  parameter int PTR_W = 7,
  parameter int TH_W  = 7,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PTR_W-1:0] in_cnt,
  input  logic [PTR_W-1:0] out_cnt,
  input  logic [TH_W-1:0]  in_thr,
  input  logic [TH_W-1:0]  out_thr,
  output logic             in_req,
  output logic             out_req,
  output logic [PTR_W-1:0] out_cnt_q
);
  localparam int CW = ((PTR_W > TH_W) ? PTR_W : TH_W) + 2;
  logic [CW-1:0] in_eff, out_eff;
  logic          in_req_d, out_req_d;

  always_comb begin
    in_eff    = (in_thr  == '0) ? CW'(1) : CW'(in_thr);
    out_eff   = (out_thr == '0) ? CW'(1) : CW'(out_thr);
    in_req_d  = (CW'(in_cnt) + in_eff) <= CW'(DEPTH);
    out_req_d = CW'(out_cnt) >= out_eff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_req    <= 1'b0;
      out_req   <= 1'b0;
      out_cnt_q <= '0;
    end else begin
      in_req    <= in_req_d;
      out_req   <= out_req_d;
      out_cnt_q <= out_cnt;
    end
  end
endmodule

// File: rtl/hostlink_fifo.sv
module hostlink_fifo
  import hostlink_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int TH_W   = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_wr,
  input  logic [DATA_W-1:0]    host_wdata,
  input  logic                 host_rd,
  output logic [DATA_W-1:0]    host_rdata,
  output logic                 host_rtag,
  output logic                 host_rvalid,
  output logic                 host_in_req,
  output logic                 host_out_req,
  output logic [ADDR_W:0]      out_status,
  input  logic                 cpu_wr,
  input  logic [DATA_W-1:0]    cpu_wdata,
  input  logic                 cpu_wtag,
  input  logic                 cpu_rd,
  output logic [DATA_W-1:0]    cpu_rdata,
  output logic                 cpu_rvalid,
  input  logic [TH_W-1:0]      in_thresh,
  input  logic [TH_W-1:0]      out_thresh,
  input  logic                 freeze,
  input  logic                 ptr_ld,
  input  logic [1:0]           ptr_sel,
  input  logic [ADDR_W-1:0]    ptr_val,
  output logic [N_ERR-1:0]     err_flags,
  input  logic [N_ERR-1:0]     err_clr
);
  localparam int PTR_W = ADDR_W;
  localparam int CH_AW = ADDR_W - 1;
  localparam int DEPTH = 2 ** CH_AW;
  localparam int MW    = DATA_W + 1;

  // Slot owner: 1 = host, 0 = processor
  logic slot_host;
  always_ff @(posedge clk) begin
    if (rst) slot_host <= 1'b1;
    else     slot_host <= ~slot_host;
  end

  logic              h_go, h_wr;
  logic [DATA_W-1:0] h_data;
  logic              c_go, c_wr;
  logic [MW-1:0]     c_data;

  hostlink_port #(.W(DATA_W)) u_host_port (
    .clk(clk), .rst(rst), .drop(freeze), .my_slot(slot_host),
    .rd_stb(host_rd), .wr_stb(host_wr), .wdata(host_wdata),
    .go(h_go), .go_wr(h_wr), .go_data(h_data)
  );

  hostlink_port #(.W(MW)) u_cpu_port (
    .clk(clk), .rst(rst), .drop(1'b0), .my_slot(~slot_host),
    .rd_stb(cpu_rd), .wr_stb(cpu_wr), .wdata({cpu_wtag, cpu_wdata}),
    .go(c_go), .go_wr(c_wr), .go_data(c_data)
  );

  // Four queue pointers, each with a wrap bit above the region address
  logic [PTR_W-1:0] ptrs [N_PTR];
  logic [N_PTR-1:0] ld_v, inc_v;

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    assign ld_v[g] = freeze & ptr_ld & (ptr_sel == 2'(g));
    hostlink_ptr #(.W(PTR_W)) u_ptr (
      .clk(clk), .rst(rst), .ld(ld_v[g]), .ld_val(ptr_val),
      .inc(inc_v[g]), .ptr(ptrs[g])
    );
  end

  logic [PTR_W-1:0] in_cnt, out_cnt;
  logic in_full, in_empty, out_full, out_empty;
  logic h_wr_ok, h_rd_ok, c_wr_ok, c_rd_ok;
  logic [N_ERR-1:0] err_set;

  always_comb begin
    in_cnt    = ptrs[P_IN_WR]  - ptrs[P_IN_RD];
    out_cnt   = ptrs[P_OUT_WR] - ptrs[P_OUT_RD];
    in_full   = in_cnt  >= PTR_W'(DEPTH);
    out_full  = out_cnt >= PTR_W'(DEPTH);
    in_empty  = in_cnt  == '0;
    out_empty = out_cnt == '0;

    h_wr_ok = h_go &  h_wr & ~in_full;
    h_rd_ok = h_go & ~h_wr & ~out_empty;
    c_wr_ok = c_go &  c_wr & ~out_full;
    c_rd_ok = c_go & ~c_wr & ~in_empty;

    err_set              = '0;
    err_set[E_IN_FULL]   = h_go &  h_wr & in_full;
    err_set[E_OUT_EMPTY] = h_go & ~h_wr & out_empty;
    err_set[E_OUT_FULL]  = c_go &  c_wr & out_full;
    err_set[E_IN_EMPTY]  = c_go & ~c_wr & in_empty;

    inc_v           = '0;
    inc_v[P_IN_RD]  = c_rd_ok;
    inc_v[P_IN_WR]  = h_wr_ok;
    inc_v[P_OUT_RD] = h_rd_ok;
    inc_v[P_OUT_WR] = c_wr_ok;
  end

  // RAM port steering: lower half inbound, upper half outbound
  logic              ram_we, ram_re;
  logic [ADDR_W-1:0] ram_addr;
  logic [MW-1:0]     ram_wdata, ram_q;

  always_comb begin
    ram_we    = h_wr_ok | c_wr_ok;
    ram_re    = h_rd_ok | c_rd_ok;
    ram_wdata = h_go ? {1'b0, h_data} : c_data;
    if (h_go)
      ram_addr = h_wr ? {1'b0, ptrs[P_IN_WR][CH_AW-1:0]}
                      : {1'b1, ptrs[P_OUT_RD][CH_AW-1:0]};
    else
      ram_addr = c_wr ? {1'b1, ptrs[P_OUT_WR][CH_AW-1:0]}
                      : {1'b0, ptrs[P_IN_RD][CH_AW-1:0]};
  end

  hostlink_ram #(.AW(ADDR_W), .DW(MW)) u_ram (
    .clk(clk), .we(ram_we), .re(ram_re), .addr(ram_addr),
    .wdata(ram_wdata), .q(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid <= 1'b0;
      cpu_rvalid  <= 1'b0;
      err_flags   <= '0;
    end else begin
      host_rvalid <= h_rd_ok;
      cpu_rvalid  <= c_rd_ok;
      err_flags   <= (err_flags & ~err_clr) | err_set;
    end
  end

  assign host_rdata = ram_q[DATA_W-1:0];
  assign host_rtag  = ram_q[DATA_W];
  assign cpu_rdata  = ram_q[DATA_W-1:0];

  logic             out_req_q;
  logic [PTR_W-1:0] out_cnt_q;

  hostlink_status #(.PTR_W(PTR_W), .TH_W(TH_W), .DEPTH(DEPTH)) u_status (
    .clk(clk), .rst(rst), .in_cnt(in_cnt), .out_cnt(out_cnt),
    .in_thr(in_thresh), .out_thr(out_thresh),
    .in_req(host_in_req), .out_req(out_req_q), .out_cnt_q(out_cnt_q)
  );

  assign host_out_req = out_req_q;
  assign out_status   = {out_req_q, out_cnt_q};
endmodule

// File: rtl/hostlink_checker.sv
module hostlink_checker #(
  parameter int ADDR_W = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            host_rvalid,
  input logic            cpu_rvalid,
  input logic            host_out_req,
  input logic [ADDR_W:0] out_status,
  input logic            freeze,
  input logic [3:0]      err_flags,
  input logic [3:0]      err_clr
);
  localparam int DEPTH = 2 ** (ADDR_W - 1);

  // R6: a side never gets read data on two clocks in a row
  assert_host_rv_spacing_R6: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |=> !host_rvalid);
  assert_cpu_rv_spacing_R6: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |=> !cpu_rvalid);

  // R6: one RAM slot per clock, so both sides never get data together
  assert_rv_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(host_rvalid && cpu_rvalid));

  // R5: a request implies at least one waiting entry
  assert_out_req_nonempty_R5: assert property (@(posedge clk) disable iff (rst)
    host_out_req |-> (out_status[ADDR_W-1:0] != '0));

  // R5: occupancy never exceeds the queue depth outside freeze
  assert_out_depth_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (!freeze && !$past(freeze)) |-> (out_status[ADDR_W-1:0] <= (ADDR_W)'(DEPTH)));

  // R7: an error bit only falls after a clear request
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ((($past(err_flags) & ~$past(err_clr)) & ~err_flags) == 4'b0));

  // R8: no host read data while frozen
  assert_frozen_host_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (freeze && $past(freeze)) |-> !host_rvalid);
endmodule

bind hostlink_fifo hostlink_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .host_rvalid(host_rvalid), .cpu_rvalid(cpu_rvalid),
  .host_out_req(host_out_req), .out_status(out_status), .freeze(freeze),
  .err_flags(err_flags), .err_clr(err_clr)
);

// File: tb/hostlink_fifo_bench.sv
module hostlink_fifo_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 0, host_rd = 0, cpu_wr = 0, cpu_rd = 0, cpu_wtag = 0;
  logic [7:0] host_wdata = 0, cpu_wdata = 0;
  logic [7:0] host_rdata, cpu_rdata;
  logic       host_rtag, host_rvalid, cpu_rvalid, host_in_req, host_out_req;
  logic [7:0] out_status;
  logic [6:0] in_thresh = 0, out_thresh = 0, ptr_val = 0;
  logic       freeze = 0, ptr_ld = 0;
  logic [1:0] ptr_sel = 0;
  logic [3:0] err_flags, err_clr = 0;

  always #5 clk = ~clk;

  hostlink_fifo u_hostlink_fifo (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .host_rtag(host_rtag),
    .host_rvalid(host_rvalid), .host_in_req(host_in_req),
    .host_out_req(host_out_req), .out_status(out_status),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_wtag(cpu_wtag),
    .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .in_thresh(in_thresh), .out_thresh(out_thresh), .freeze(freeze),
    .ptr_ld(ptr_ld), .ptr_sel(ptr_sel), .ptr_val(ptr_val),
    .err_flags(err_flags), .err_clr(err_clr)
  );

  int nchk = 0, nerr = 0, cyc = 0;

  // Reference model: memory image, pointers with wrap bit, error bits
  logic [8:0] mm [128];
  logic [6:0] m_ird = 0, m_iwr = 0, m_ord = 0, m_owr = 0;
  logic [3:0] m_err = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int icnt(); return int'(7'(m_iwr - m_ird)); endfunction
  function automatic int ocnt(); return int'(7'(m_owr - m_ord)); endfunction
  function automatic int eff(input int t); return (t == 0) ? 1 : t; endfunction

  task automatic check_status(input string rq);
    int oreq;
    oreq = (ocnt() >= eff(int'(out_thresh))) ? 1 : 0;
    chk({rq, " R5 out_status"}, int'(out_status), oreq * 128 + ocnt());
    chk({rq, " R5 host_out_req"}, int'(host_out_req), oreq);
    chk({rq, " R4 host_in_req"}, int'(host_in_req),
        ((64 - icnt()) >= eff(int'(in_thresh))) ? 1 : 0);
    chk({rq, " R7 err_flags"}, int'(err_flags), int'(m_err));
  endtask

  task automatic set_thr(input int ti, input int to);
    @(negedge clk); in_thresh = 7'(ti); out_thresh = 7'(to);
    repeat (2) @(negedge clk);
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk); host_wr = 1; host_wdata = d;
    @(negedge clk); host_wr = 0;
    repeat (2) @(negedge clk);
    if (!freeze) begin
      if (icnt() >= 64) m_err[0] = 1;
      else begin mm[{1'b0, m_iwr[5:0]}] = {1'b0, d}; m_iwr++; end
    end
  endtask

  task automatic cpu_write(input logic [7:0] d, input logic t);
    @(negedge clk); cpu_wr = 1; cpu_wdata = d; cpu_wtag = t;
    @(negedge clk); cpu_wr = 0;
    repeat (2) @(negedge clk);
    if (ocnt() >= 64) m_err[2] = 1;
    else begin mm[{1'b1, m_owr[5:0]}] = {t, d}; m_owr++; end
  endtask

  // Reads: count rvalid pulses over the three following negedges
  task automatic host_read(input string rq);
    int n = 0, at = 0; logic [7:0] got = 0; logic gt = 0; int expn;
    @(negedge clk); host_rd = 1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk); host_rd = 0;
      if (host_rvalid) begin n++; at = k; got = host_rdata; gt = host_rtag; end
    end
    expn = (freeze || ocnt() == 0) ? 0 : 1;
    chk({rq, " host rvalid count"}, n, expn);
    if (expn == 1 && n == 1) begin
      chk({rq, " R6 served within one extra cycle"}, (at <= 2) ? 1 : 0, 1);
      chk({rq, " R3 host_rdata"}, int'(got), int'(mm[{1'b1, m_ord[5:0]}][7:0]));
      chk({rq, " R3 host_rtag"}, int'(gt), int'(mm[{1'b1, m_ord[5:0]}][8]));
      m_ord++;
    end else if (!freeze && ocnt() == 0) m_err[3] = 1;
  endtask

  task automatic cpu_read(input string rq);
    int n = 0, at = 0; logic [7:0] got = 0; int expn;
    @(negedge clk); cpu_rd = 1;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk); cpu_rd = 0;
      if (cpu_rvalid) begin n++; at = k; got = cpu_rdata; end
    end
    expn = (icnt() == 0) ? 0 : 1;
    chk({rq, " cpu rvalid count"}, n, expn);
    if (expn == 1 && n == 1) begin
      chk({rq, " R6 served within one extra cycle"}, (at <= 2) ? 1 : 0, 1);
      chk({rq, " R2 cpu_rdata"}, int'(got), int'(mm[{1'b0, m_ird[5:0]}][7:0]));
      m_ird++;
    end else if (icnt() == 0) m_err[1] = 1;
  endtask

  task automatic ptr_load(input int sel, input logic [6:0] v);
    @(negedge clk); ptr_ld = 1; ptr_sel = 2'(sel); ptr_val = v;
    @(negedge clk); ptr_ld = 0;
    @(negedge clk);
    if (freeze) case (sel)
      0: m_ird = v; 1: m_iwr = v; 2: m_ord = v; default: m_owr = v;
    endcase
  endtask

  task automatic err_clear(input logic [3:0] m);
    @(negedge clk); err_clr = m;
    @(negedge clk); err_clr = 0;
    @(negedge clk);
    m_err &= ~m;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 out_status after reset", int'(out_status), 0);
    chk("R1 err_flags after reset", int'(err_flags), 0);
    chk("R1 host_in_req after reset", int'(host_in_req), 1);
    chk("R1 rvalids after reset", int'(host_rvalid) + int'(cpu_rvalid), 0);

    // R2/R4: fill inbound, sweep thresholds around the free count
    for (int i = 0; i <= 64; i++) begin
      host_write(8'(i * 37 + 5));
      for (int s = 0; s < 3; s++) begin
        int fr = 64 - icnt();
        set_thr((s == 0) ? 0 : ((s == 1) ? fr : fr + 1), 0);
        check_status("R4 inbound sweep");
      end
    end
    // R7 overflow recorded above; drain with one underflow
    for (int i = 0; i <= 64; i++) cpu_read("R2 drain");
    check_status("R7 after inbound errors");
    err_clear(4'b0011);
    check_status("R7 after clear");
    // R2 wraparound
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < 40; i++) host_write(8'(r * 50 + i));
      for (int i = 0; i < 40; i++) cpu_read("R2 wrap");
    end
    check_status("R2 after wrap");

    // R3/R5: fill outbound with tags, sweep output thresholds
    for (int i = 0; i <= 64; i++) begin
      cpu_write(8'(i * 11 + 1), (i % 3) == 0);
      for (int s = 0; s < 5; s++) begin
        int tv;
        case (s) 0: tv = 0; 1: tv = 1; 2: tv = ocnt(); 3: tv = ocnt() + 1;
          default: tv = 127; endcase
        set_thr(0, tv);
        check_status("R5 outbound sweep");
      end
    end
    for (int i = 0; i <= 64; i++) host_read("R3 drain");
    check_status("R7 after outbound errors");
    err_clear(4'b1100);
    set_thr(0, 0);

    // R6: host and processor strobe in the same cycle
    host_write(8'hA5);
    cpu_write(8'h3C, 1'b1);
    begin
      int hn = 0, cn = 0, both = 0;
      @(negedge clk); host_rd = 1; cpu_rd = 1;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk); host_rd = 0; cpu_rd = 0;
        if (host_rvalid) begin hn++;
          chk("R6 concurrent host data", int'(host_rdata), 8'h3C); end
        if (cpu_rvalid) begin cn++;
          chk("R6 concurrent cpu data", int'(cpu_rdata), 8'hA5); end
        if (host_rvalid && cpu_rvalid) both++;
      end
      chk("R6 concurrent host count", hn, 1);
      chk("R6 concurrent cpu count", cn, 1);
      chk("R6 no shared slot", both, 0);
      m_ird++; m_ord++;
    end
    check_status("R6 after concurrent");

    // R8: freeze drops host traffic and allows pointer loads
    @(negedge clk); freeze = 1; @(negedge clk);
    host_write(8'h77);
    host_read("R8 frozen read");
    check_status("R8 frozen host write dropped");
    ptr_load(2, 7'(m_owr - 3));
    check_status("R8 loaded outbound read pointer");
    @(negedge clk); freeze = 0; @(negedge clk);
    for (int i = 0; i < 3; i++) host_read("R8 replay");
    check_status("R8 after replay");
    cpu_read("R8 inbound stays empty");
    err_clear(4'b0010);

    // R9: load while not frozen does nothing
    ptr_load(3, 7'(m_owr + 5));
    check_status("R9 ignored load");
    cpu_write(8'h5A, 1'b0);
    host_read("R9 normal path");
    check_status("R9 final");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule